// File: doc/BRIEF.md
# Fan Stall Detector With Latched Alert

This block watches a fan and declares a failure when the fan has stopped or is missing. It uses two criteria. The first is that the tachometer input has shown no edge for a programmable number of slow ticks, nominally about half a second. The second is that a run of consecutive speed measurements has each come back at the counter's saturated full-scale value. A run of 8 such measurements takes about a quarter of a second.

The tachometer input arrives already synchronized. The measurement strobe and count come from a separate speed counter. When a failure is declared, a latch drives the active-low interrupt output low and raises a fail status bit.

Detection runs only while the fan-detect enable is high. Clearing the interrupt takes two steps in order. Software first drops the enable, and then an alert-response-address read completes on the serial bus. While the enable is low, both criteria are held at zero, so turning detection back on starts both of them fresh.

Top module: `fan_stall_guard`

## Requirements
- R1: After reset, `alert_n_o` is 1 and `fan_fail_o` is 0.
- R2: While `det_en_i` is 0, no failure is declared, whatever the tachometer and measurement inputs do.
- R3: With `det_en_i` at 1, when no tachometer edge (either direction) arrives for `TIMEOUT_TICKS` ticks, failure is declared. One tick is `TICK_DIV` clock cycles, and the tick divider restarts on every edge. Failure becomes visible on the second clock edge after the count completes.
- R4: With `det_en_i` at 1, `SAT_RUNS` consecutive `meas_done_i` strobes (default 8) whose `meas_count_i` is all ones (255 at the default 8-bit width) declare failure. Failure becomes visible on the second clock edge after the last such strobe.
- R5: A declared failure drives `alert_n_o` to 0 and `fan_fail_o` (status bit 0, fan fail) to 1, and the two outputs are always complements of each other.
- R6: An `ara_read_i` strobe while `det_en_i` is 1 leaves the alert and the fail bit set.
- R7: An `ara_read_i` strobe while `det_en_i` is 0 clears the failure, so that `alert_n_o` is 1 and `fan_fail_o` is 0 after the next clock edge.
- R8: A measurement strobe carrying any count below full scale restarts the saturated run from zero.
- R9: Dropping `det_en_i` for a cycle and raising it again restarts both the timeout and the saturated run from zero.
- R10: Once set, the failure stays latched until it is cleared as in R7. Disabling detection alone does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_i | input | 1 | Synchronized tachometer input |
| meas_done_i | input | 1 | Speed measurement complete strobe |
| meas_count_i | input | CNT_W | Speed measurement result |
| det_en_i | input | 1 | Fan-detect enable |
| ara_read_i | input | 1 | Alert-response-address read completed strobe |
| alert_n_o | output | 1 | Active-low interrupt |
| fan_fail_o | output | 1 | Fan fail status bit |

## Verification
Several rules are checked by the bound checker on every cycle:
- a failure never appears while detection is off;
- the latch survives any cycle without a qualifying clear, and survives an alert-response read made while detection is enabled;
- a read made with detection off clears the latch;
- a finished timeout or saturated run sets the latch one cycle later;
- both criteria sit at zero while disabled.

Other behaviours need the bench's scenarios to show them:
- the exact cycle in which an edge-free interval ends in a failure;
- a single unsaturated measurement breaking a run of 8;
- partial progress being discarded across a disable and re-enable;
- the ordering of the two clearing steps.

// File: rtl/fan_stall_guard.sv
module fan_stall_guard #(
  parameter int CNT_W         = 8,
  parameter int SAT_RUNS      = 8,
  parameter int TICK_DIV      = 64,
  parameter int TIMEOUT_TICKS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_i,
  input  logic             meas_done_i,
  input  logic [CNT_W-1:0] meas_count_i,
  input  logic             det_en_i,
  input  logic             ara_read_i,
  output logic             alert_n_o,
  output logic             fan_fail_o
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam int SW = $clog2(SAT_RUNS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [TW-1:0] TO_LAST  = TW'(TIMEOUT_TICKS);
  localparam logic [SW-1:0] SAT_LAST = SW'(SAT_RUNS);

  logic          tach_q;
  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] to_cnt;
  logic [SW-1:0] sat_cnt;
  logic          fail_q;

  wire tach_edge = tach_i ^ tach_q;
  wire tick      = (pre_cnt == PRE_LAST);
  wire full_meas = (meas_count_i == {CNT_W{1'b1}});
  wire to_hit    = (to_cnt == TO_LAST);
  wire sat_hit   = (sat_cnt == SAT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) tach_q <= 1'b0;
    else        tach_q <= tach_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !det_en_i || tach_edge) begin
      pre_cnt <= '0;
      to_cnt  <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick && !to_hit) to_cnt <= to_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !det_en_i)        sat_cnt <= '0;
    else if (meas_done_i && !full_meas) sat_cnt <= '0;
    else if (meas_done_i && !sat_hit)   sat_cnt <= sat_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            fail_q <= 1'b0;
    else if (det_en_i && (to_hit || sat_hit)) fail_q <= 1'b1;
    else if (!det_en_i && ara_read_i)      fail_q <= 1'b0;
  end

  assign fan_fail_o = fail_q;
  assign alert_n_o  = ~fail_q;
endmodule

// File: rtl/fan_stall_guard_chk.sv
module fan_stall_guard_chk #(
  parameter int TW = 1,
  parameter int SW = 1,
  parameter int SAT_RUNS = 8,
  parameter int TIMEOUT_TICKS = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          det_en_i,
  input logic          ara_read_i,
  input logic          fan_fail_o,
  input logic          alert_n_o,
  input logic [TW-1:0] to_cnt,
  input logic [SW-1:0] sat_cnt
);
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en_i && !fan_fail_o) |=> !fan_fail_o); // R2
  AST_TIMEOUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en_i && to_cnt == TW'(TIMEOUT_TICKS)) |=> fan_fail_o); // R3
  AST_RUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en_i && sat_cnt == SW'(SAT_RUNS)) |=> (fan_fail_o && !alert_n_o)); // R4
  AST_ARA_ENABLED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_fail_o && det_en_i) |=> fan_fail_o); // R6
  AST_CLEAR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_fail_o && !det_en_i && ara_read_i) |=> (!fan_fail_o && alert_n_o)); // R7
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en_i |=> (to_cnt == '0 && sat_cnt == '0)); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_fail_o && !ara_read_i) |=> fan_fail_o); // R10
endmodule

bind fan_stall_guard fan_stall_guard_chk #(
  .TW(TW), .SW(SW), .SAT_RUNS(SAT_RUNS), .TIMEOUT_TICKS(TIMEOUT_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .det_en_i(det_en_i), .ara_read_i(ara_read_i),
  .fan_fail_o(fan_fail_o), .alert_n_o(alert_n_o),
  .to_cnt(to_cnt), .sat_cnt(sat_cnt)
);

// File: tb/test_fan_stall_guard.sv
`timescale 1ns/1ps
module test_fan_stall_guard;
  localparam int TDIV = 4;
  localparam int TTO  = 10;
  localparam int TO_CYC = TDIV * TTO + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tach = 1'b0, done = 1'b0, en = 1'b0, ara = 1'b0;
  logic [7:0] cnt = 8'd0;
  logic alert_n, fail;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fan_stall_guard #(.CNT_W(8), .SAT_RUNS(8), .TICK_DIV(TDIV), .TIMEOUT_TICKS(TTO)) i_fan_stall_guard (
    .clk(clk), .rst_n(rst_n), .tach_i(tach), .meas_done_i(done), .meas_count_i(cnt),
    .det_en_i(en), .ara_read_i(ara), .alert_n_o(alert_n), .fan_fail_o(fail));

  task automatic chk(input string req, input logic exp_fail);
    n_chk++;
    if (fail !== exp_fail || alert_n !== ~exp_fail) begin
      n_bad++;
      $display("FAIL %s: fail=%b alert_n=%b expected fail=%b alert_n=%b",
               req, fail, alert_n, exp_fail, ~exp_fail);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic meas(input logic [7:0] v);
    tach = ~tach; done = 1'b1; cnt = v;
    cyc(1);
    done = 1'b0;
    cyc(1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; ara = 1'b0; done = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic clear_alert();
    en = 1'b0; cyc(1);
    ara = 1'b1; cyc(1);
    ara = 1'b0; cyc(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset state", 1'b0);
  endtask

  task automatic t_disabled();
    en = 1'b0;
    for (int i = 0; i < 12; i++) begin done = 1'b1; cnt = 8'hFF; cyc(1); done = 1'b0; cyc(1); end
    cyc(TO_CYC + 10);
    chk("R2 disabled no failure", 1'b0);
  endtask

  task automatic t_running();
    en = 1'b1;
    for (int i = 0; i < 30; i++) meas(8'd120);
    chk("R3 running fan no timeout", 1'b0);
  endtask

  task automatic t_timeout();
    en = 1'b1;
    tach = ~tach;
    cyc(TO_CYC - 4);
    chk("R3 before timeout", 1'b0);
    cyc(6);
    chk("R3 timeout declares failure", 1'b1);
    chk("R5 alert low with fail bit", 1'b1);
  endtask

  task automatic t_clear();
    ara = 1'b1; cyc(1); ara = 1'b0; cyc(2);
    chk("R6 ara while enabled keeps alert", 1'b1);
    en = 1'b0; cyc(5);
    chk("R10 disable alone keeps alert", 1'b1);
    ara = 1'b1; cyc(1); ara = 1'b0;
    chk("R7 disable then ara clears", 1'b0);
  endtask

  task automatic t_saturate();
    en = 1'b1;
    for (int i = 0; i < 7; i++) meas(8'hFF);
    meas(8'd254);
    for (int i = 0; i < 7; i++) meas(8'hFF);
    chk("R8 short run broken by low count", 1'b0);
    meas(8'd10);
    for (int i = 0; i < 7; i++) meas(8'hFF);
    chk("R4 seven saturated not enough", 1'b0);
    meas(8'hFF);
    chk("R4 eighth saturated declares failure", 1'b1);
    clear_alert();
    chk("R7 cleared after saturation", 1'b0);
  endtask

  task automatic t_restart();
    en = 1'b1;
    for (int i = 0; i < 6; i++) meas(8'hFF);
    en = 1'b0; cyc(1); en = 1'b1;
    for (int i = 0; i < 6; i++) meas(8'hFF);
    chk("R9 saturated run restarts on re-enable", 1'b0);
    tach = ~tach;
    cyc(TO_CYC - 6);
    en = 1'b0; cyc(1); en = 1'b1;
    cyc(TO_CYC - 6);
    chk("R9 timeout restarts on re-enable", 1'b0);
    cyc(10);
    chk("R3 timeout after restart", 1'b1);
  endtask

  task automatic t_reset_clears();
    do_reset();
    chk("R1 reset clears latched alert", 1'b0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_running();
    t_timeout();
    t_clear();
    t_saturate();
    t_restart();
    t_reset_clears();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule